// File: doc/BRIEF.md
# Hierarchical 64-line priority encoder

The block takes 64 request lines and reports the index of the highest-numbered line that is active, together with a flag that says whether any line is active. It is built the way a wide priority encoder is put together from small parts. Eight identical 8-line slices each resolve priority inside their own group. An enable chain runs from the top group down to the bottom group, so a group is allowed to report only when every group above it is empty. A ninth small encoder takes the one-per-group "this group won" flags and produces the upper three index bits. The lower three index bits are the OR of all eight slice codes. That OR only works because every slice that lost, or that has no request, drives an all-zero code.

Priority resolution is combinational. A parameter puts a register stage on the index and valid outputs, and this stage is on by default. With the stage enabled the outputs follow the requests one clock later, and an active-low asynchronous reset clears them. All signals are active high.

Top module: `prienc_hier64`

## Requirements
- R1: When at least one request is active, `index` equals the highest-numbered active request line. Request bit 63 beats every other line.
- R2: Within one group of 8 lines, the higher-numbered line wins. For example, the group pattern 8'b1010_1010 in lines 7..0 yields low index bits 3'b111, and 8'b0000_0110 yields 3'b010.
- R3: A group that is disabled, or that has no active line, contributes 3'b000 to the OR merge and does not raise its group-won flag. As a result, at most one group-won flag is ever high, and a win at line 56 together with line 7 active yields index 56, not 63.
- R4: The topmost group (lines 63..56) is always enabled. Any active line there decides the result, whatever the lower groups hold.
- R5: A lower group reports only when every higher group has no active line. The enable passed out of a group is high only when that group is enabled and empty. The enable leaving the bottom group is high exactly when no request is active.
- R6: `index[5:3]` equals the number of the highest group (request lines 8g+7..8g) that has an active line.
- R7: `index[2:0]` equals the position, inside the winning group, of that group's highest active line.
- R8: `valid` is high exactly when any request is active. When no request is active, `index` is 0 and `valid` is 0.
- R9: With the register stage enabled (default), `index` and `valid` show the result for the requests present at the previous rising clock edge. While `rst_n` is low, both outputs are 0. With the stage disabled, the outputs follow the requests directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| req | input | 64 | Request lines; bit 63 has the highest priority |
| index | output | 6 | Index of the highest active request, 0 when none |
| valid | output | 1 | High when any request is active |

## Verification
A slice that leaks a nonzero code while disabled corrupts only the low three index bits. This shows up as soon as a higher group wins while a lower group holds a line with different low bits, so the bench pairs such patterns on purpose. A broken link in the enable chain produces either two group-won flags or none. That fault appears as wrong upper index bits, or a wrong `valid`, in the same cycle on the combinational instance and one clock later on the registered one. The bench compares every output of both variants with a top-down scan of the request word after each new pattern. The patterns are all 64 single-line words, the empty word, the full word, cross-group pairs and random sparse words.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

  localparam int PE_MAXW = 64;
  localparam int PE_MAXLW = $clog2(PE_MAXW);

  // Keep only the highest set bit of v (one-hot or zero result).
  function automatic logic [PE_MAXW-1:0] pe_keep_highest(input logic [PE_MAXW-1:0] v);
    logic [PE_MAXW-1:0] h;
    logic seen;
    h = '0;
    seen = 1'b0;
    for (int i = PE_MAXW - 1; i >= 0; i--) begin
      h[i] = v[i] & ~seen;
      seen = seen | v[i];
    end
    return h;
  endfunction

  // Binary code of a one-hot word: bit b is the OR of all h[i] with bit b of i set.
  function automatic logic [PE_MAXLW-1:0] pe_encode(input logic [PE_MAXW-1:0] h);
    logic [PE_MAXLW-1:0] e;
    e = '0;
    for (int i = 0; i < PE_MAXW; i++) begin
      if (h[i]) e = e | PE_MAXLW'(i);
    end
    return e;
  endfunction

endpackage

// File: rtl/prienc_slice.sv
module prienc_slice
  import prienc_pkg::*;
#(
  parameter int W  = 8,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  input  logic          en_in,
  output logic [LW-1:0] code,
  output logic          grp_sel,
  output logic          en_out,
  output logic          idle
);

  logic [PE_MAXW-1:0]  pad;
  logic [PE_MAXW-1:0]  hot;
  logic [PE_MAXLW-1:0] enc;
  logic                any_req;

  always_comb begin
    pad = '0;
    pad[W-1:0] = req;
    hot = pe_keep_highest(pad);
    enc = pe_encode(hot);
  end

  assign any_req = |req;
  assign idle    = ~any_req;
  // Disabled or empty slices drive zero so the cross-slice OR stays correct.
  assign code    = (en_in && any_req) ? enc[LW-1:0] : '0;
  assign grp_sel = en_in & any_req;
  assign en_out  = en_in & ~any_req;

endmodule

// File: rtl/prienc_or_merge.sv
module prienc_or_merge #(
  parameter int NUM = 8,
  parameter int LW  = 3
) (
  input  logic [NUM*LW-1:0] codes,
  output logic [LW-1:0]     merged
);

  always_comb begin
    merged = '0;
    for (int k = 0; k < NUM; k++) begin
      merged = merged | codes[k*LW +: LW];
    end
  end

endmodule

// File: rtl/prienc_out_stage.sv
module prienc_out_stage #(
  parameter int IW         = 6,
  parameter bit REGISTERED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx_d,
  input  logic          valid_d,
  output logic [IW-1:0] idx_q,
  output logic          valid_q
);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          idx_q   <= '0;
          valid_q <= 1'b0;
        end else begin
          idx_q   <= idx_d;
          valid_q <= valid_d;
        end
      end
    end else begin : g_comb
      assign idx_q   = idx_d;
      assign valid_q = valid_d;
    end
  endgenerate

endmodule

// File: rtl/prienc_hier64.sv
module prienc_hier64 #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int N_IN = SLICE_W * NUM_SLICES,
  localparam int SLW  = $clog2(SLICE_W),
  localparam int GW   = $clog2(NUM_SLICES),
  localparam int IW   = SLW + GW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] req,
  output logic [IW-1:0]   index,
  output logic            valid
);

  // Named internal events, observed by the bound checker.
  logic [NUM_SLICES:0]         en_link;
  logic [NUM_SLICES-1:0]       grp_sel_vec;
  logic [NUM_SLICES-1:0]       slice_idle;
  logic [NUM_SLICES*SLW-1:0]   slice_code_flat;
  logic [SLW-1:0]              low_code;
  logic [GW-1:0]               grp_code;
  logic                        grp_valid;
  logic                        grp_en_out;
  logic                        grp_idle;
  logic [IW-1:0]               core_idx;
  logic                        core_valid;

  // Top slice is always enabled.
  assign en_link[NUM_SLICES] = 1'b1;

  generate
    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      prienc_slice #(.W(SLICE_W), .LW(SLW)) u_slice (
        .req     (req[k*SLICE_W +: SLICE_W]),
        .en_in   (en_link[k+1]),
        .code    (slice_code_flat[k*SLW +: SLW]),
        .grp_sel (grp_sel_vec[k]),
        .en_out  (en_link[k]),
        .idle    (slice_idle[k])
      );
    end
  endgenerate

  prienc_or_merge #(.NUM(NUM_SLICES), .LW(SLW)) u_merge (
    .codes  (slice_code_flat),
    .merged (low_code)
  );

  prienc_slice #(.W(NUM_SLICES), .LW(GW)) u_group (
    .req     (grp_sel_vec),
    .en_in   (1'b1),
    .code    (grp_code),
    .grp_sel (grp_valid),
    .en_out  (grp_en_out),
    .idle    (grp_idle)
  );

  assign core_idx   = {grp_code, low_code};
  assign core_valid = grp_valid;

  prienc_out_stage #(.IW(IW), .REGISTERED(REGISTERED)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_d   (core_idx),
    .valid_d (core_valid),
    .idx_q   (index),
    .valid_q (valid)
  );

endmodule

// File: rtl/prienc_hier64_chk.sv
module prienc_hier64_chk #(
  parameter int N_IN       = 64,
  parameter int NUM_SLICES = 8,
  parameter int SLW        = 3,
  parameter int IW         = 6,
  parameter bit REGISTERED = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_IN-1:0]           req,
  input logic [IW-1:0]             index,
  input logic                      valid,
  input logic [NUM_SLICES:0]       en_link,
  input logic [NUM_SLICES-1:0]     grp_sel_vec,
  input logic [NUM_SLICES-1:0]     slice_idle,
  input logic [NUM_SLICES*SLW-1:0] slice_code_flat,
  input logic [IW-1:0]             core_idx,
  input logic                      core_valid,
  input logic                      grp_en_out,
  input logic                      grp_idle
);

  assert_top_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> ((req >> core_idx) == N_IN'(1)));

  assert_slice_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&slice_idle) == (req == '0));

  assert_one_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_sel_vec));

  assert_top_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req[N_IN-1 -: (N_IN/NUM_SLICES)]) |-> grp_sel_vec[NUM_SLICES-1]);

  assert_chain_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_link[0] == (req == '0));

  assert_upper_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> grp_sel_vec[core_idx[IW-1:SLW]]);

  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_valid |-> (core_idx == '0 && slice_code_flat == '0 && grp_idle && grp_en_out));

  assert_valid_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid == (req != '0));

  generate
    if (REGISTERED) begin : g_chk_reg
      assert_out_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (index == $past(core_idx) && valid == $past(core_valid)));
    end else begin : g_chk_comb
      assert_out_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        index == core_idx && valid == core_valid);
    end
  endgenerate

endmodule

bind prienc_hier64 prienc_hier64_chk #(
  .N_IN(N_IN), .NUM_SLICES(NUM_SLICES), .SLW(SLW), .IW(IW), .REGISTERED(REGISTERED)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req             (req),
  .index           (index),
  .valid           (valid),
  .en_link         (en_link),
  .grp_sel_vec     (grp_sel_vec),
  .slice_idle      (slice_idle),
  .slice_code_flat (slice_code_flat),
  .core_idx        (core_idx),
  .core_valid      (core_valid),
  .grp_en_out      (grp_en_out),
  .grp_idle        (grp_idle)
);

// File: tb/test_prienc_hier64.sv
module test_prienc_hier64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic [5:0]  index, index_c;
  logic        valid, valid_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prienc_hier64 i_prienc_hier64 (
    .clk(clk), .rst_n(rst_n), .req(req), .index(index), .valid(valid)
  );

  prienc_hier64 #(.REGISTERED(1'b0)) i_prienc_hier64_comb (
    .clk(clk), .rst_n(rst_n), .req(req), .index(index_c), .valid(valid_c)
  );

  // Reference: scan from line 63 down; returns {valid, index}.
  function automatic logic [6:0] ref_scan(input logic [63:0] v);
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) return {1'b1, 6'(i)};
    end
    return 7'd0;
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h req=%h", tag, act, exp, req);
    end
  endtask

  // Drive a pattern, check the direct variant, then the registered one after the edge.
  task automatic apply(input string tag, input logic [63:0] v);
    logic [6:0] e;
    e = ref_scan(v);
    @(negedge clk);
    req = v;
    #2;
    check({tag, " comb"}, {valid_c, index_c}, e);
    check("R6 upper", {4'd0, index_c[5:3]}, {4'd0, e[5:3]});
    check("R7 lower", {4'd0, index_c[2:0]}, {4'd0, e[2:0]});
    check("R8 valid", {6'd0, valid_c}, {6'd0, e[6]});
    @(posedge clk);
    #2;
    check({tag, " R9 reg"}, {valid, index}, e);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    req = '1;
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset holds zero", {valid, index}, 7'd0);
    @(negedge clk);
    rst_n = 1'b1;

    apply("R8 empty", 64'd0);
    apply("R1 full", '1);
    for (int i = 0; i < 64; i++) begin
      apply("R1 single", 64'd1 << i);
    end
    apply("R2 alternating", 64'h0000_0000_0000_00AA);
    apply("R2 low pair", 64'h0000_0000_0000_0006);
    apply("R2 mid group", 64'h0000_0000_5500_0000);
    apply("R3 leak 56+7", (64'd1 << 56) | 64'd1 << 7);
    apply("R3 leak 8+7", (64'd1 << 8) | 64'h7F);
    apply("R3 leak 40+all", (64'd1 << 40) | 64'h0000_00FF_FFFF_FFFF);
    apply("R4 top beats all", (64'd1 << 57) | 64'h00FF_FFFF_FFFF_FFFF);
    apply("R4 top only low", 64'h0100_0000_0000_0000);
    for (int g = 0; g < 8; g++) begin
      for (int h = 0; h < g; h++) begin
        apply("R5 pair groups", (64'd1 << (8 * g)) | (64'hFF << (8 * h)));
      end
    end
    for (int n = 0; n < 300; n++) begin
      logic [63:0] r;
      r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if (n % 3 == 0) r = r >> (n % 64);
      apply("R1 random", r);
    end
    apply("R8 empty again", 64'd0);

    @(negedge clk);
    req = 64'h8000_0000_0000_0000;
    rst_n = 1'b0;
    #2;
    check("R9 async reset clears", {valid, index}, 7'd0);
    check("R9 comb ignores reset", {valid_c, index_c}, {1'b1, 6'd63});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule